// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block stores a 32×32 two-plane cursor and mixes it into a scanned-out pixel stream. Software reaches it through a 32-bit register port. A packed position register holds the cursor corner, 32 mask words and 32 image words hold the shape one row per word, and a miscellaneous register is kept for software. The pixel stream enters as valid, x, y and an underlying colour. It leaves two cycles later with the same x, y and valid, and with the colour replaced wherever the cursor is opaque.

Each pixel that lies under the cursor takes one bit from its mask word and one from its image word. A clear mask bit lets the underlying colour through. A set mask bit selects one of two overlay colours, which an external palette supplies on the overlay colour inputs. After reset the cursor sits far off-screen, so nothing is drawn until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, pix_valid_o is 0 and a read of offset 0x818 returns 0x02000000.
- R2: A write to offset 0x8FC sets cursor X to data bits 31:16 and cursor Y to data bits 15:0.
- R3: A write to offset 0x900 + 4·r (r = 0..31) sets mask row r, and a write to 0x980 + 4·r sets image row r. Cursor row r (y − cursor Y = r) uses mask row r and image row r.
- R4: Within a row, bit 31 belongs to the pixel at cursor X, and bit 31 − c belongs to the pixel at cursor X + c.
- R5: Under the cursor, mask bit 1 with image bit 1 outputs ov_hi_color_i, and mask bit 1 with image bit 0 outputs ov_lo_color_i. A pixel with mask bit 0 outputs its own input colour.
- R6: Only rows with cursor Y ≤ y < cursor Y + 32 are affected, compared as 16-bit unsigned values. A cursor near Y = 0xFFFF does not wrap onto row 0.
- R7: Pixels are affected only when cursor X < SCREEN_W, only at columns cursor X ≤ x < cursor X + 32, and only at x < SCREEN_W. Columns beyond the screen width are clipped.
- R8: Reset puts cursor X and Y at 0xF000. Until the position is written, no pixel is altered, whatever the shape words hold.
- R9: Offset 0x818 stores a written word, and a read returns that word OR 0x02000000. A read of any other offset returns 0, including the position, mask and image offsets.
- R10: pix_valid_o, pix_x_o, pix_y_o and pix_color_o follow the matching input pixel by exactly two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 16 | Input pixel column |
| pix_y_i | input | 16 | Input pixel row |
| pix_color_i | input | COLOR_W | Underlying pixel colour |
| ov_lo_color_i | input | COLOR_W | Overlay colour for mask 1 / image 0 |
| ov_hi_color_i | input | COLOR_W | Overlay colour for mask 1 / image 1 |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_x_o | output | 16 | Output pixel column |
| pix_y_o | output | 16 | Output pixel row |
| pix_color_o | output | COLOR_W | Merged pixel colour |

## Verification
Some behaviour is checked on every cycle. The assertions cover the two-cycle carry of valid, x and y, the packing of position writes, the storage of shape words and the forced bit in misc reads. They also check that the colour passes through unchanged wherever the cursor misses, and that a cursor X at or past the width never hits. Other behaviour can only be shown by the bench scenarios, because it depends on the whole shape. These scenarios sweep full screen rows around the cursor and compare every pixel with a model computed from the written words. They cover the mask and image encoding, MSB-first column order, the row window with its lack of wrap at the top of the coordinate space, right-edge clipping and the parked reset position.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
  localparam int unsigned REG_AW  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned COORD_W = 16;
  localparam int unsigned CUR_DIM = DATA_W;
  localparam int unsigned IDX_W   = $clog2(CUR_DIM);

  localparam logic [REG_AW-1:0]  OFF_MISC = 12'h818;
  localparam logic [REG_AW-1:0]  OFF_POS  = 12'h8FC;
  localparam logic [REG_AW-1:0]  OFF_MASK = 12'h900;
  localparam logic [REG_AW-1:0]  OFF_IMG  = 12'h980;

  localparam logic [COORD_W-1:0] POS_PARK   = 16'hF000;
  localparam logic [DATA_W-1:0]  MISC_FORCE = 32'h0200_0000;

  typedef enum logic [1:0] {
    SEL_UNDER = 2'd0,
    SEL_OV_LO = 2'd1,
    SEL_OV_HI = 2'd2
  } pix_sel_e;
endpackage

// File: rtl/cursor_plane.sv
module cursor_plane
  import cursor_overlay_pkg::*;
#(
  parameter logic [REG_AW-1:0] BASE = OFF_MASK,
  parameter int unsigned       ROWS = CUR_DIM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_row_i,
  output logic [DATA_W-1:0] row_o
);
  localparam logic [REG_AW-1:0] SPAN = REG_AW'(ROWS * 4);

  logic [REG_AW-1:0] rel;
  logic              sel;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] mem_q [ROWS];

  assign rel    = addr_i - BASE;
  assign sel    = we_i && (addr_i >= BASE) && (rel < SPAN);
  assign wr_idx = IDX_W'(rel >> 2);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[r] <= '0;
      else if (sel && wr_idx == IDX_W'(r))     mem_q[r] <= wdata_i;
    end
  end

  assign row_o = mem_q[rd_row_i];

  p_word_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |=> mem_q[$past(wr_idx)] == $past(wdata_i));
endmodule

// File: rtl/cursor_ctrl_regs.sv
module cursor_ctrl_regs
  import cursor_overlay_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [COORD_W-1:0] cur_x_o,
  output logic [COORD_W-1:0] cur_y_o
);
  logic [DATA_W-1:0] misc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_x_o <= POS_PARK;
      cur_y_o <= POS_PARK;
    end else if (we_i && addr_i == OFF_POS) begin
      cur_x_o <= wdata_i[31:16];
      cur_y_o <= wdata_i[15:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         misc_q <= '0;
    else if (we_i && addr_i == OFF_MISC) misc_q <= wdata_i;
  end

  assign rdata_o = (addr_i == OFF_MISC) ? (misc_q | MISC_FORCE) : '0;

  p_pos_pack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_POS) |=>
      (cur_x_o == $past(wdata_i[31:16]) && cur_y_o == $past(wdata_i[15:0])));

  p_misc_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_MISC) |-> rdata_o[25]);

  p_misc_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_MISC) |=> (rdata_o | MISC_FORCE) ==
      ((addr_i == OFF_MISC) ? ($past(wdata_i) | MISC_FORCE) : MISC_FORCE));
endmodule

// File: rtl/cursor_pipe.sv
module cursor_pipe
  import cursor_overlay_pkg::*;
#(
  parameter int unsigned SCREEN_W = 1024,
  parameter int unsigned COLOR_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  output logic [IDX_W-1:0]   row_idx_o,
  input  logic [DATA_W-1:0]  mask_row_i,
  input  logic [DATA_W-1:0]  img_row_i,
  input  logic               pix_valid_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [COLOR_W-1:0] pix_color_i,
  input  logic [COLOR_W-1:0] ov_lo_color_i,
  input  logic [COLOR_W-1:0] ov_hi_color_i,
  output logic               pix_valid_o,
  output logic [COORD_W-1:0] pix_x_o,
  output logic [COORD_W-1:0] pix_y_o,
  output logic [COLOR_W-1:0] pix_color_o
);
  localparam logic [COORD_W-1:0] WIDTH_C = COORD_W'(SCREEN_W);
  localparam logic [COORD_W-1:0] DIM_C   = COORD_W'(CUR_DIM);

  logic [COORD_W-1:0] dx, dy;
  logic               row_in, col_in, hit_c;

  // 16-bit differences avoid the wrap that cursor+32 would have
  assign dx     = pix_x_i - cur_x_i;
  assign dy     = pix_y_i - cur_y_i;
  assign row_in = (pix_y_i >= cur_y_i) && (dy < DIM_C);
  assign col_in = (pix_x_i >= cur_x_i) && (dx < DIM_C) && (pix_x_i < WIDTH_C);
  assign hit_c  = (cur_x_i < WIDTH_C) && row_in && col_in;
  assign row_idx_o = dy[IDX_W-1:0];

  // stage 1: window decode and row fetch
  logic               s1_valid, s1_hit;
  logic [COORD_W-1:0] s1_x, s1_y;
  logic [COLOR_W-1:0] s1_color;
  logic [IDX_W-1:0]   s1_col;
  logic [DATA_W-1:0]  s1_mask, s1_img;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_color <= '0;
      s1_col   <= '0;
      s1_mask  <= '0;
      s1_img   <= '0;
    end else begin
      s1_valid <= pix_valid_i;
      s1_hit   <= hit_c;
      s1_x     <= pix_x_i;
      s1_y     <= pix_y_i;
      s1_color <= pix_color_i;
      s1_col   <= dx[IDX_W-1:0];
      s1_mask  <= mask_row_i;
      s1_img   <= img_row_i;
    end
  end

  // stage 2: bit pick (MSB = leftmost) and colour select
  logic [IDX_W-1:0] bit_pos;
  pix_sel_e         sel;
  logic [COLOR_W-1:0] mix_c;

  assign bit_pos = IDX_W'(CUR_DIM - 1) - s1_col;

  always_comb begin
    sel = SEL_UNDER;
    if (s1_hit && s1_mask[bit_pos]) sel = s1_img[bit_pos] ? SEL_OV_HI : SEL_OV_LO;
  end

  always_comb begin
    unique case (sel)
      SEL_OV_LO: mix_c = ov_lo_color_i;
      SEL_OV_HI: mix_c = ov_hi_color_i;
      default:   mix_c = s1_color;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_x_o     <= '0;
      pix_y_o     <= '0;
      pix_color_o <= '0;
    end else begin
      pix_valid_o <= s1_valid;
      pix_x_o     <= s1_x;
      pix_y_o     <= s1_y;
      pix_color_o <= mix_c;
    end
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  p_carry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2) &&
      pix_x_o == $past(pix_x_i, 2) && pix_y_o == $past(pix_y_i, 2)));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_hit |=> pix_color_o == $past(s1_color));

  p_xgate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_x_i >= WIDTH_C) |=> !s1_hit);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter int unsigned SCREEN_W = 1024,
  parameter int unsigned COLOR_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               pix_valid_i,
  input  logic [15:0]        pix_x_i,
  input  logic [15:0]        pix_y_i,
  input  logic [COLOR_W-1:0] pix_color_i,
  input  logic [COLOR_W-1:0] ov_lo_color_i,
  input  logic [COLOR_W-1:0] ov_hi_color_i,
  output logic               pix_valid_o,
  output logic [15:0]        pix_x_o,
  output logic [15:0]        pix_y_o,
  output logic [COLOR_W-1:0] pix_color_o
);
  logic [COORD_W-1:0] cur_x, cur_y;
  logic [IDX_W-1:0]   row_idx;
  logic [DATA_W-1:0]  plane_row [2];

  cursor_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cur_x_o (cur_x),
    .cur_y_o (cur_y)
  );

  // plane 0 = mask, plane 1 = image
  for (genvar p = 0; p < 2; p++) begin : g_plane
    cursor_plane #(
      .BASE ((p == 0) ? OFF_MASK : OFF_IMG),
      .ROWS (CUR_DIM)
    ) u_plane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (reg_we_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .rd_row_i (row_idx),
      .row_o    (plane_row[p])
    );
  end

  cursor_pipe #(
    .SCREEN_W (SCREEN_W),
    .COLOR_W  (COLOR_W)
  ) u_pipe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cur_x_i       (cur_x),
    .cur_y_i       (cur_y),
    .row_idx_o     (row_idx),
    .mask_row_i    (plane_row[0]),
    .img_row_i     (plane_row[1]),
    .pix_valid_i   (pix_valid_i),
    .pix_x_i       (pix_x_i),
    .pix_y_i       (pix_y_i),
    .pix_color_i   (pix_color_i),
    .ov_lo_color_i (ov_lo_color_i),
    .ov_hi_color_i (ov_hi_color_i),
    .pix_valid_o   (pix_valid_o),
    .pix_x_o       (pix_x_o),
    .pix_y_o       (pix_y_o),
    .pix_color_o   (pix_color_o)
  );
endmodule

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;
  localparam int W  = 64;
  localparam int CW = 24;
  localparam logic [CW-1:0] OV_LO = 24'h3C3C3C;
  localparam logic [CW-1:0] OV_HI = 24'hC3C3C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        pv = 1'b0;
  logic [15:0] px = '0, py = '0;
  logic [CW-1:0] pc = '0;
  logic        ov;
  logic [15:0] ox, oy;
  logic [CW-1:0] oc;

  cursor_overlay #(.SCREEN_W(W), .COLOR_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pix_valid_i(pv), .pix_x_i(px), .pix_y_i(py), .pix_color_i(pc),
    .ov_lo_color_i(OV_LO), .ov_hi_color_i(OV_HI),
    .pix_valid_o(ov), .pix_x_o(ox), .pix_y_o(oy), .pix_color_o(oc)
  );

  int total = 0, fails = 0;
  logic [15:0] m_cx = 16'hF000, m_cy = 16'hF000;
  logic [31:0] m_mask [32];
  logic [31:0] m_img  [32];
  logic [31:0] m_misc = '0;

  // two-deep history of driven pixels
  logic          hv [2];
  logic [15:0]   hx [2], hy [2];
  logic [CW-1:0] hc [2];
  string         htag = "R5";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] under(input logic [15:0] x, input logic [15:0] y);
    return {x[7:0], y[7:0], 8'h5A};
  endfunction

  function automatic logic [CW-1:0] model(input logic [15:0] x, input logic [15:0] y);
    logic [15:0] dx, dy;
    int b;
    dx = x - m_cx;
    dy = y - m_cy;
    if (m_cx < 16'(W) && y >= m_cy && dy < 16'd32 && x >= m_cx && dx < 16'd32 && x < 16'(W)) begin
      b = 31 - int'(dx);
      if (m_mask[dy[4:0]][b]) return m_img[dy[4:0]][b] ? OV_HI : OV_LO;
    end
    return under(x, y);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 12'h8FC) begin m_cx = d[31:16]; m_cy = d[15:0]; end
    if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
    if (a >= 12'h980 && a < 12'hA00) m_img[(a - 12'h980) >> 2] = d;
    if (a == 12'h818) m_misc = d;
  endtask

  task automatic step(input logic v, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    chk("R10 valid", {31'd0, ov}, {31'd0, hv[1]});
    if (hv[1]) begin
      chk("R10 x", {16'd0, ox}, {16'd0, hx[1]});
      chk("R10 y", {16'd0, oy}, {16'd0, hy[1]});
      chk(htag, {8'd0, oc}, {8'd0, hc[1]});
    end
    hv[1] = hv[0]; hx[1] = hx[0]; hy[1] = hy[0]; hc[1] = hc[0];
    hv[0] = v; hx[0] = x; hy[0] = y; hc[0] = model(x, y);
    pv = v; px = x; py = y; pc = under(x, y);
  endtask

  task automatic scan(input string tag, input logic [15:0] y0, input int rows);
    htag = tag;
    for (int r = 0; r < rows; r++)
      for (int x = 0; x < W; x++) step(1'b1, 16'(x), y0 + 16'(r));
    step(1'b0, 16'd0, 16'd0);
    step(1'b0, 16'd0, 16'd0);
  endtask

  task automatic load_shape(input logic [31:0] km, input logic [31:0] ki);
    for (int r = 0; r < 32; r++) begin
      wr(12'h900 + 12'(4 * r), km * 32'(r + 1));
      wr(12'h980 + 12'(4 * r), ki * 32'(r + 3));
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) begin m_mask[r] = '0; m_img[r] = '0; end
    for (int i = 0; i < 2; i++) begin hv[i] = 1'b0; hx[i] = '0; hy[i] = '0; hc[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid", {31'd0, ov}, 32'd0);
    addr = 12'h818; #1;
    chk("R1 misc", rdata, 32'h0200_0000);

    // R8 parked cursor: full shape, no pixel altered
    for (int r = 0; r < 32; r++) begin wr(12'h900 + 12'(4 * r), '1); wr(12'h980 + 12'(4 * r), '1); end
    scan("R8", 16'd0, 3);
    htag = "R8";
    step(1'b1, 16'hF000, 16'hF000);
    step(1'b1, 16'hF01F, 16'hF01F);
    step(1'b0, 0, 0); step(1'b0, 0, 0);

    // R2 R3 R4 R5 R6 full window, patterned rows
    load_shape(32'h9E37_79B9, 32'h85EB_CA6B);
    wr(12'h8FC, {16'd10, 16'd5});
    scan("R3/R4/R5/R6 R2", 16'd3, 36);

    // R7 right-edge clip
    wr(12'h8FC, {16'd50, 16'd20});
    scan("R7 clip", 16'd19, 3);
    scan("R7 clip", 16'd50, 3);

    // R7 X at screen width: nothing drawn
    wr(12'h8FC, {16'd64, 16'd0});
    scan("R7 xgate", 16'd0, 2);

    // R6 top of coordinate space: no wrap to row 0
    wr(12'h8FC, {16'd0, 16'hFFF0});
    scan("R6 nowrap", 16'hFFFE, 2);
    scan("R6 nowrap", 16'd0, 2);

    // R9 misc register and zero reads
    wr(12'h818, 32'h1234_5678);
    addr = 12'h818; #1;
    chk("R9 misc", rdata, 32'h1234_5678 | 32'h0200_0000);
    addr = 12'h904; #1;
    chk("R9 mask zero", rdata, 32'd0);
    addr = 12'h8FC; #1;
    chk("R9 pos zero", rdata, 32'd0);
    addr = 12'h9FC; #1;
    chk("R9 img zero", rdata, 32'd0);

    // R10 gaps in valid
    htag = "R10";
    step(1'b1, 16'd1, 16'd1); step(1'b0, 0, 0); step(1'b1, 16'd2, 16'd7);
    step(1'b0, 0, 0); step(1'b0, 0, 0); step(1'b0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule